// File: doc/BRIEF.md
# Sampled page miss counter unit

This unit sits beside one memory node and watches every request that arrives there. It samples one request in every `SAMPLE_PERIOD`. For a sampled request it finds the local page and keeps a small countdown counter for each requesting node, plus one written flag per page. The counters start at a trigger threshold and count down. When the counter of a remote requester reaches zero on a page above the static kernel range, the unit issues a one-cycle hot-page event. The event carries the local page, the requester and the home node. A separate queue block consumes the events, and a separate sweeper clears the counters periodically.

Software reaches the storage through a single-cycle 64-bit register port. A read of the counters returns all node counters of one page packed into one word, with 4-bit or 8-bit fields. A read of the written flag returns a one-hot word. A global enable turns the register port off: reads return zero and writes are ignored. Sampling runs whatever the enable is.

Top module: `pmc_page_miss_counter`

## Requirements
- R1: A sample countdown loads `SAMPLE_PERIOD` at reset and decrements on every cycle with `req_valid_i` high. The request that brings it to zero is processed, and the countdown then reloads to `SAMPLE_PERIOD`. All other requests change no counter or flag.
- R2: The local page of a request is `(req_addr_i >> PAGE_SHIFT) mod PAGES`. A processed request acts only on the counter of that page for node `req_node_i`, so addresses that alias to the same local page share a counter.
- R3: After reset every counter holds `THRESH`, every written flag is clear, and `hot_valid_o` and `reg_rdata_o` are zero.
- R4: A processed request decrements the selected counter by one. A counter at zero stays at zero.
- R5: When a processed request takes a counter from 1 to 0, `hot_valid_o` pulses for one cycle, starting the cycle after the sampling edge. This happens only if the global page `req_addr_i >> PAGE_SHIFT` is greater than `KERN_PAGES` and `req_node_i` differs from `HOME_NODE`. During the pulse, `hot_page_o` is the local page, `hot_node_o` is the requester and `hot_home_o` is `HOME_NODE`.
- R6: The request kind is coded on `req_kind_i` as 0 shared read, 1 exclusive read, 2 upgrade, 3 other. A processed request of kind 1 or 2 sets the written flag of its page. Kinds 0 and 3 leave the flag unchanged.
- R7: With `ZERO_ON_WRITE` set, a processed request of kind 1 or 2 reloads `THRESH` into the counters of every other node for that page. The requester's own counter still follows R4.
- R8: A register read (`reg_en_i`=1, `reg_we_i`=0, `reg_sel_i`=0) of page `reg_idx_i` puts node i's counter at bits `[CNT_W*i +: CNT_W]` of `reg_rdata_o`, with all other bits zero. `CNT_W` is 4 (up to 16 nodes) or 8 (`WIDE_CNT`, up to 8 nodes). The result appears the cycle after the access and holds until the next read.
- R9: With `reg_sel_i`=1, a read returns bit `reg_idx_i mod 64` set if the page's written flag is set, and zero otherwise. A write of a nonzero `reg_wdata_i` sets the flag, and a write of zero clears it.
- R10: While `count_en_i` is low, register reads return zero and register writes change nothing.
- R11: A register write with `reg_sel_i`=0 loads node i's counter of page `reg_idx_i` from `reg_wdata_i[CNT_W*i +: CNT_W]`. Higher bits are ignored.
- R12: A register write to a page's counters or flag in the same cycle as a processed request to that page wins. The request's change to that same storage (decrement, re-arm or flag set) is dropped, and no hot event results from a dropped decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_en_i | input | 1 | Global enable of the register port |
| req_valid_i | input | 1 | A request arrives this cycle |
| req_addr_i | input | ADDR_W | Request byte address |
| req_node_i | input | NODE_W | Requesting node |
| req_kind_i | input | 2 | Request kind (see R6) |
| reg_en_i | input | 1 | Register access this cycle |
| reg_we_i | input | 1 | 1 write, 0 read |
| reg_sel_i | input | 1 | 0 counters, 1 written flag |
| reg_idx_i | input | PAGE_W | Local page addressed |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data, registered |
| hot_valid_o | output | 1 | Hot-page event pulse |
| hot_page_o | output | PAGE_W | Local page of the event |
| hot_node_o | output | NODE_W | Requester of the event |
| hot_home_o | output | NODE_W | Home node of the event |

## Verification
The hardest case to reach from the ports is a register write that lands in exactly the cycle in which a sampled request hits the same page. Only every Nth request is processed, so this needs an exact alignment. The bench tracks the sample countdown from reset by counting every request it sends, adds filler requests to other pages, and then drives the register write together with the request that completes the period. Hot-event suppression is reached in a similar way: the bench runs a counter down to one for a kernel page and for the home node, then sends the processed request that would otherwise fire.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    KIND_RD_SHARED = 2'd0,
    KIND_RD_EXCL   = 2'd1,
    KIND_UPGRADE   = 2'd2,
    KIND_OTHER     = 2'd3
  } req_kind_e;

  localparam int unsigned REG_W = 64;

  function automatic logic kind_is_write(req_kind_e k);
    return (k == KIND_RD_EXCL) || (k == KIND_UPGRADE);
  endfunction
endpackage

// File: rtl/pmc_sampler.sv
module pmc_sampler #(
  parameter int unsigned PERIOD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic fire_o
);
  localparam int unsigned CW = (PERIOD < 2) ? 1 : $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = tick_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CW'(PERIOD);
    else if (tick_i) cnt_q <= fire_o ? CW'(PERIOD) : cnt_q - CW'(1);
  end

  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !fire_o |=> cnt_q == $past(cnt_q) - CW'(1));
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  assert_nonzero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
endmodule

// File: rtl/pmc_flag_bank.sv
module pmc_flag_bank #(
  parameter int unsigned PAGES = 16,
  localparam int unsigned PAGE_W = $clog2(PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [PAGE_W-1:0] set_page_i,
  input  logic              reg_wr_i,
  input  logic [PAGE_W-1:0] reg_page_i,
  input  logic              reg_val_i,
  output logic              flag_o
);
  logic [PAGES-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else begin
      for (int p = 0; p < PAGES; p++) begin
        if (reg_wr_i && reg_page_i == PAGE_W'(p)) flag_q[p] <= reg_val_i;
        else if (set_i && set_page_i == PAGE_W'(p)) flag_q[p] <= 1'b1;
      end
    end
  end

  assign flag_o = flag_q[reg_page_i];

  assert_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !(reg_wr_i && reg_page_i == set_page_i) |=> flag_q[$past(set_page_i)]);
  assert_regwin_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> flag_q[$past(reg_page_i)] == $past(reg_val_i));
  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> ($past(flag_q) & ~flag_q) == '0);
endmodule

// File: rtl/pmc_counter_bank.sv
module pmc_counter_bank #(
  parameter int unsigned NODES         = 4,
  parameter int unsigned PAGES         = 16,
  parameter int unsigned CNT_W         = 4,
  parameter int unsigned THRESH        = 2,
  parameter bit          ZERO_ON_WRITE = 1'b1,
  localparam int unsigned PAGE_W = $clog2(PAGES),
  localparam int unsigned NODE_W = $clog2(NODES),
  localparam int unsigned PACK_W = NODES * CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [PAGE_W-1:0] upd_page_i,
  input  logic [NODE_W-1:0] upd_node_i,
  input  logic              upd_write_i,
  input  logic              reg_wr_i,
  input  logic [PAGE_W-1:0] reg_page_i,
  input  logic [PACK_W-1:0] reg_wdata_i,
  output logic [PACK_W-1:0] rd_word_o,
  output logic              zero_hit_o
);
  localparam logic [CNT_W-1:0] TVAL = CNT_W'(THRESH);

  logic [CNT_W-1:0] cnt_q [PAGES][NODES];
  logic             blocked, upd_ok;
  logic [CNT_W-1:0] cur_cnt;

  assign blocked    = reg_wr_i && (reg_page_i == upd_page_i);
  assign upd_ok     = upd_i && !blocked;
  assign cur_cnt    = cnt_q[upd_page_i][upd_node_i];
  assign zero_hit_o = upd_ok && (cur_cnt == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < PAGES; p++)
        for (int n = 0; n < NODES; n++)
          cnt_q[p][n] <= TVAL;
    end else begin
      for (int p = 0; p < PAGES; p++) begin
        for (int n = 0; n < NODES; n++) begin
          if (reg_wr_i && reg_page_i == PAGE_W'(p)) begin
            cnt_q[p][n] <= reg_wdata_i[n*CNT_W +: CNT_W];
          end else if (upd_ok && upd_page_i == PAGE_W'(p)) begin
            if (upd_node_i == NODE_W'(n)) begin
              if (cnt_q[p][n] != '0) cnt_q[p][n] <= cnt_q[p][n] - CNT_W'(1);
            end else if (ZERO_ON_WRITE && upd_write_i) begin
              cnt_q[p][n] <= TVAL;  // re-arm other nodes on a write
            end
          end
        end
      end
    end
  end

  for (genvar n = 0; n < NODES; n++) begin : g_pack
    assign rd_word_o[n*CNT_W +: CNT_W] = cnt_q[reg_page_i][n];
  end

  assert_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_ok && cur_cnt == '0 |=> cnt_q[$past(upd_page_i)][$past(upd_node_i)] == '0);
  assert_decr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_ok && cur_cnt != '0 |=>
      cnt_q[$past(upd_page_i)][$past(upd_node_i)] == $past(cur_cnt) - CNT_W'(1));
  assert_regwin_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> cnt_q[$past(reg_page_i)][0] == $past(reg_wdata_i[CNT_W-1:0]));
endmodule

// File: rtl/pmc_page_miss_counter.sv
module pmc_page_miss_counter
  import pmc_pkg::*;
#(
  parameter int unsigned NODES         = 4,
  parameter int unsigned PAGES         = 16,
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned PAGE_SHIFT    = 12,
  parameter int unsigned SAMPLE_PERIOD = 3,
  parameter int unsigned THRESH        = 2,
  parameter int unsigned KERN_PAGES    = 4,
  parameter int unsigned HOME_NODE     = 0,
  parameter bit          WIDE_CNT      = 1'b0,
  parameter bit          ZERO_ON_WRITE = 1'b1,
  localparam int unsigned NODE_W = $clog2(NODES),
  localparam int unsigned PAGE_W = $clog2(PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              count_en_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic [1:0]        req_kind_i,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [PAGE_W-1:0] reg_idx_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              hot_valid_o,
  output logic [PAGE_W-1:0] hot_page_o,
  output logic [NODE_W-1:0] hot_node_o,
  output logic [NODE_W-1:0] hot_home_o
);
  localparam int unsigned CNT_W   = WIDE_CNT ? 8 : 4;
  localparam int unsigned PACK_W  = NODES * CNT_W;
  localparam int unsigned GPAGE_W = ADDR_W - PAGE_SHIFT;

  req_kind_e          kind;
  logic [GPAGE_W-1:0] gpage;
  logic [PAGE_W-1:0]  lpage;
  logic               fire, is_write, zero_hit, kern_ok, remote, hot_d;
  logic               wr_cnt, wr_flag, flag_rd;
  logic [PACK_W-1:0]  cnt_word;
  logic [63:0]        rd_next, rdata_q;
  logic               hot_valid_q;
  logic [PAGE_W-1:0]  hot_page_q;
  logic [NODE_W-1:0]  hot_node_q;

  assign kind     = req_kind_e'(req_kind_i);
  assign is_write = kind_is_write(kind);
  assign gpage    = GPAGE_W'(req_addr_i >> PAGE_SHIFT);
  assign lpage    = PAGE_W'(gpage % GPAGE_W'(PAGES));

  assign wr_cnt  = reg_en_i && reg_we_i && count_en_i && !reg_sel_i;
  assign wr_flag = reg_en_i && reg_we_i && count_en_i && reg_sel_i;

  pmc_sampler #(.PERIOD(SAMPLE_PERIOD)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (req_valid_i),
    .fire_o (fire)
  );

  pmc_counter_bank #(
    .NODES(NODES), .PAGES(PAGES), .CNT_W(CNT_W),
    .THRESH(THRESH), .ZERO_ON_WRITE(ZERO_ON_WRITE)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (fire),
    .upd_page_i  (lpage),
    .upd_node_i  (req_node_i),
    .upd_write_i (is_write),
    .reg_wr_i    (wr_cnt),
    .reg_page_i  (reg_idx_i),
    .reg_wdata_i (reg_wdata_i[PACK_W-1:0]),
    .rd_word_o   (cnt_word),
    .zero_hit_o  (zero_hit)
  );

  pmc_flag_bank #(.PAGES(PAGES)) u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (fire && is_write),
    .set_page_i (lpage),
    .reg_wr_i   (wr_flag),
    .reg_page_i (reg_idx_i),
    .reg_val_i  (|reg_wdata_i),
    .flag_o     (flag_rd)
  );

  always_comb begin
    if (!count_en_i)    rd_next = '0;
    else if (reg_sel_i) rd_next = flag_rd ? (64'd1 << 6'(reg_idx_i)) : '0;
    else                rd_next = 64'(cnt_word);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (reg_en_i && !reg_we_i) rdata_q <= rd_next;
  end

  assign kern_ok = gpage > GPAGE_W'(KERN_PAGES);
  assign remote  = req_node_i != NODE_W'(HOME_NODE);
  assign hot_d   = zero_hit && kern_ok && remote;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_valid_q <= 1'b0;
      hot_page_q  <= '0;
      hot_node_q  <= '0;
    end else begin
      hot_valid_q <= hot_d;
      if (hot_d) begin
        hot_page_q <= lpage;
        hot_node_q <= req_node_i;
      end
    end
  end

  assign reg_rdata_o = rdata_q;
  assign hot_valid_o = hot_valid_q;
  assign hot_page_o  = hot_page_q;
  assign hot_node_o  = hot_node_q;
  assign hot_home_o  = NODE_W'(HOME_NODE);

  assert_hot_remote_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_valid_o |-> hot_node_o != hot_home_o);
  assert_hot_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_valid_o |-> $past(req_valid_i));
  assert_rd_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_en_i && !reg_we_i && !count_en_i |=> reg_rdata_o == '0);
  assert_flag_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_en_i && !reg_we_i && reg_sel_i |=> $onehot0(reg_rdata_o));
  assert_pack_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_en_i && !reg_we_i && !reg_sel_i |=> (reg_rdata_o >> PACK_W) == '0);
endmodule

// File: tb/pmc_page_miss_counter_tb_top.sv
`timescale 1ns/1ps
module pmc_page_miss_counter_tb_top;
  localparam logic [2:0] OP_REQ = 3'd0, OP_RDC = 3'd1, OP_RDF = 3'd2,
                         OP_WRC = 3'd3, OP_WRF = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] addr;   // byte address for requests, page index for register ops
    logic [1:0]  node;
    logic [1:0]  kind;
    logic        en;
    logic [63:0] wdata;
    logic        hot;
    logic [63:0] exp;
    logic [3:0]  rq;
  } vec_t;

  // Defaults: 4 nodes, 16 pages, 4 KiB pages, sample 1 in 3, threshold 2,
  // kernel pages 0..4, home node 0, 4-bit fields, re-arm on write.
  localparam int NV = 52;
  localparam vec_t VECS [NV] = '{
    '{OP_REQ, 32'h5000, 2'd2, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},       // R1 not sampled
    '{OP_REQ, 32'h5000, 2'd2, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h5000, 2'd2, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd4},       // R4 2->1
    '{OP_RDC, 32'd5,    2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h2122, 4'd8},    // R8 packing
    '{OP_REQ, 32'h5000, 2'd2, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h5000, 2'd2, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h15000,2'd2, 2'd0, 1'b1, 64'd0, 1'b1, 64'd0, 4'd5},       // R5 alias page 5 (R2), hot
    '{OP_REQ, 32'h5000, 2'd2, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd5},
    '{OP_REQ, 32'h5000, 2'd2, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h5000, 2'd2, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd4},       // R4 stays at zero, no event
    '{OP_RDC, 32'd5,    2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h2022, 4'd4},
    '{OP_REQ, 32'h3000, 2'd1, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h3000, 2'd1, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h3000, 2'd1, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd4},
    '{OP_REQ, 32'h3000, 2'd1, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h3000, 2'd1, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h3000, 2'd1, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd5},       // R5 kernel page, no event
    '{OP_RDC, 32'd3,    2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h2202, 4'd2},
    '{OP_REQ, 32'h7000, 2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h7000, 2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h7000, 2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd4},
    '{OP_REQ, 32'h7000, 2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h7000, 2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h7000, 2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd5},       // R5 home requester, no event
    '{OP_RDC, 32'd7,    2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h2220, 4'd5},
    '{OP_REQ, 32'h9000, 2'd1, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h9000, 2'd1, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h9000, 2'd1, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd4},
    '{OP_REQ, 32'h9000, 2'd3, 2'd1, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h9000, 2'd3, 2'd1, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'h9000, 2'd3, 2'd1, 1'b1, 64'd0, 1'b0, 64'd0, 4'd7},       // R7 exclusive re-arms node 1
    '{OP_RDC, 32'd9,    2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h1222, 4'd7},
    '{OP_RDF, 32'd9,    2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h200, 4'd6},     // R6 flag from exclusive
    '{OP_RDF, 32'd5,    2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd6},
    '{OP_REQ, 32'hA000, 2'd2, 2'd2, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'hA000, 2'd2, 2'd2, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'hA000, 2'd2, 2'd2, 1'b1, 64'd0, 1'b0, 64'd0, 4'd6},
    '{OP_RDF, 32'd10,   2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h400, 4'd6},     // R6 flag from upgrade
    '{OP_REQ, 32'hB000, 2'd2, 2'd3, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'hB000, 2'd2, 2'd3, 1'b1, 64'd0, 1'b0, 64'd0, 4'd1},
    '{OP_REQ, 32'hB000, 2'd2, 2'd3, 1'b1, 64'd0, 1'b0, 64'd0, 4'd6},
    '{OP_RDF, 32'd11,   2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd6},       // R6 kind 3 no flag
    '{OP_RDC, 32'd11,   2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h2122, 4'd2},
    '{OP_WRC, 32'd12,   2'd0, 2'd0, 1'b1, 64'hFFFF_0000_0000_4321, 1'b0, 64'd0, 4'd11},
    '{OP_RDC, 32'd12,   2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h4321, 4'd11},   // R11
    '{OP_WRF, 32'd12,   2'd0, 2'd0, 1'b1, 64'h80, 1'b0, 64'd0, 4'd9},
    '{OP_RDF, 32'd12,   2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h1000, 4'd9},    // R9 set
    '{OP_WRF, 32'd12,   2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd9},
    '{OP_RDF, 32'd12,   2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'd0, 4'd9},       // R9 clear
    '{OP_WRC, 32'd12,   2'd0, 2'd0, 1'b0, 64'h1111, 1'b0, 64'd0, 4'd10},
    '{OP_RDC, 32'd12,   2'd0, 2'd0, 1'b0, 64'd0, 1'b0, 64'd0, 4'd10},      // R10 read disabled
    '{OP_RDC, 32'd12,   2'd0, 2'd0, 1'b1, 64'd0, 1'b0, 64'h4321, 4'd10}    // R10 write ignored
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        count_en, req_valid, reg_en, reg_we, reg_sel;
  logic [31:0] req_addr;
  logic [1:0]  req_node, req_kind;
  logic [3:0]  reg_idx;
  logic [63:0] reg_wdata, reg_rdata;
  logic        hot_valid;
  logic [3:0]  hot_page;
  logic [1:0]  hot_node, hot_home;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk_i = ~clk_i;

  pmc_page_miss_counter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_en_i(count_en),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_node_i(req_node),
    .req_kind_i(req_kind), .reg_en_i(reg_en), .reg_we_i(reg_we),
    .reg_sel_i(reg_sel), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .hot_valid_o(hot_valid), .hot_page_o(hot_page),
    .hot_node_o(hot_node), .hot_home_o(hot_home)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    count_en = 1'b1; req_valid = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
    reg_sel = 1'b0; reg_idx = '0; reg_wdata = '0;
    req_addr = '0; req_node = '0; req_kind = '0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic req(input logic [31:0] a, input logic [1:0] n, input logic [1:0] k);
    req_valid = 1'b1; req_addr = a; req_node = n; req_kind = k;
  endtask

  task automatic regop(input logic we, input logic sel, input logic [3:0] idx,
                       input logic [63:0] wd);
    reg_en = 1'b1; reg_we = we; reg_sel = sel; reg_idx = idx; reg_wdata = wd;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    idle();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R3 hot after reset", 64'(hot_valid), 64'd0);
    chk("R3 rdata after reset", reg_rdata, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    regop(1'b0, 1'b0, 4'd0, '0); tick(); idle();
    chk("R3 counters at threshold", reg_rdata, 64'h2222);
    regop(1'b0, 1'b1, 4'd0, '0); tick(); idle();
    chk("R3 flag clear", reg_rdata, 64'd0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      idle();
      count_en = v.en;
      case (v.op)
        OP_REQ:  req(v.addr, v.node, v.kind);
        OP_RDC:  regop(1'b0, 1'b0, v.addr[3:0], '0);
        OP_RDF:  regop(1'b0, 1'b1, v.addr[3:0], '0);
        OP_WRC:  regop(1'b1, 1'b0, v.addr[3:0], v.wdata);
        default: regop(1'b1, 1'b1, v.addr[3:0], v.wdata);
      endcase
      tick();
      idle();
      chk($sformatf("R%0d vec %0d hot", v.rq, i), 64'(hot_valid), 64'(v.hot));
      if (v.hot) begin
        chk($sformatf("R%0d vec %0d hot page", v.rq, i), 64'(hot_page), 64'((v.addr >> 12) % 16));
        chk($sformatf("R%0d vec %0d hot node", v.rq, i), 64'(hot_node), 64'(v.node));
        chk($sformatf("R%0d vec %0d hot home", v.rq, i), 64'(hot_home), 64'd0);
      end
      if (v.op == OP_RDC || v.op == OP_RDF)
        chk($sformatf("R%0d vec %0d rdata", v.rq, i), reg_rdata, v.exp);
    end

    // R12: counter write collides with the sampled exclusive request (33 sent so far)
    req(32'hE000, 2'd1, 2'd0); tick(); idle();
    req(32'hE000, 2'd1, 2'd0); tick(); idle();
    req(32'hD000, 2'd3, 2'd1); regop(1'b1, 1'b0, 4'd13, 64'h5555); tick(); idle();
    chk("R12 no event on collision", 64'(hot_valid), 64'd0);
    regop(1'b0, 1'b0, 4'd13, '0); tick(); idle();
    chk("R12 counter write wins", reg_rdata, 64'h5555);
    regop(1'b0, 1'b1, 4'd13, '0); tick(); idle();
    chk("R12 flag still set by request", reg_rdata, 64'h2000);
    // R12: flag write collides; counters still updated with re-arm (R7)
    req(32'hE000, 2'd1, 2'd0); tick(); idle();
    req(32'hE000, 2'd1, 2'd0); tick(); idle();
    req(32'hD000, 2'd3, 2'd1); regop(1'b1, 1'b1, 4'd13, 64'd0); tick(); idle();
    regop(1'b0, 1'b1, 4'd13, '0); tick(); idle();
    chk("R12 flag write wins", reg_rdata, 64'd0);
    regop(1'b0, 1'b0, 4'd13, '0); tick(); idle();
    chk("R7 re-arm with own decrement", reg_rdata, 64'h4222);

    // R5 with counter seeded by R11 write: node 1 at one
    regop(1'b1, 1'b0, 4'd5, 64'h0010); tick(); idle();
    req(32'hE000, 2'd2, 2'd0); tick(); idle();
    req(32'hE000, 2'd2, 2'd0); tick(); idle();
    req(32'h5000, 2'd1, 2'd0); tick(); idle();
    chk("R5 event raised", 64'(hot_valid), 64'd1);
    chk("R5 event page", 64'(hot_page), 64'd5);
    chk("R5 event node", 64'(hot_node), 64'd1);
    tick();
    chk("R5 event one cycle", 64'(hot_valid), 64'd0);

    // R3 reset mid-run, then R1 countdown restarts from the period
    rst_ni = 1'b0; tick();
    chk("R3 rdata in reset", reg_rdata, 64'd0);
    rst_ni = 1'b1; tick();
    regop(1'b0, 1'b0, 4'd13, '0); tick(); idle();
    chk("R3 counters reloaded", reg_rdata, 64'h2222);
    regop(1'b0, 1'b1, 4'd9, '0); tick(); idle();
    chk("R3 flags cleared", reg_rdata, 64'd0);
    req(32'h5000, 2'd2, 2'd0); tick(); idle();
    req(32'h5000, 2'd2, 2'd0); tick(); idle();
    regop(1'b0, 1'b0, 4'd5, '0); tick(); idle();
    chk("R1 two requests unsampled", reg_rdata, 64'h2222);
    req(32'h5000, 2'd2, 2'd0); tick(); idle();
    regop(1'b0, 1'b0, 4'd5, '0); tick(); idle();
    chk("R1 third request sampled", reg_rdata, 64'h2122);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule